// File: doc/BRIEF.md
# Normal/Sleep Power Mode Controller

This block keeps track of whether the device runs in its normal mode or its low-power sleep mode. Power-on reset always starts it in normal mode. Sleep is entered only through an explicit sleep command, and that command is honoured only while serial register access is allowed. Once asleep, the controller returns to normal mode when any qualified wake source fires:

- an enabled switch input reports a change of state;
- the active-low wake pin falls;
- the active-low interrupt pin falls while the logic supply is present and the wake pin is high;
- the active-low chip-select pin falls while the logic supply is present;
- the interrupt timer expires.

The three pins are asynchronous. Each one passes through a two-flop synchronizer, and a falling edge is then detected by comparing the synchronized level with its previous value. Edge detection is held off on the first cycle after reset. The logic-supply flag qualifies two of the wake sources and the serial-programming enable, but it never changes the mode by itself. The serial-programming enable is registered and is high only in normal mode with the logic supply present.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `mode_sleep` is 0 (normal) and `spi_en` is 0.
- R2: A `sleep_cmd` pulse sampled while `spi_en` is 1 sets `mode_sleep` to 1 at that clock edge. A `sleep_cmd` pulse sampled while `spi_en` is 0 has no effect.
- R3: In sleep mode, a cycle where `sw_change[i]` and `sw_wake_en[i]` are both 1 for any bit i returns the controller to normal mode at that edge. Change events on bits whose enable is 0 are ignored.
- R4: In sleep mode, a falling edge on `wake_n` returns the controller to normal mode on the third rising clock edge after the pin falls. The logic supply plays no part in this wake source.
- R5: In sleep mode, a falling edge on `int_n` wakes the controller only if `supply_ok` is 1 and the synchronized `wake_n` is 1. The latency is the same as in R4.
- R6: In sleep mode, a falling edge on `cs_n` wakes the controller only if `supply_ok` is 1. The latency is the same as in R4.
- R7: In sleep mode, a cycle with `timer_expire` at 1 returns the controller to normal mode at that edge.
- R8: Changing `supply_ok` never changes `mode_sleep`, whether the controller is in normal or sleep mode.
- R9: `spi_en` is registered. After each edge it equals (the new mode is normal) AND (`supply_ok` sampled at that edge).
- R10: In normal mode, wake sources have no effect. Rising edges on any pin never wake the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_cmd | input | 1 | One-cycle sleep command pulse |
| supply_ok | input | 1 | Logic supply present (synchronous level) |
| sw_change | input | NUM_SW | Per-switch change-of-state pulses |
| sw_wake_en | input | NUM_SW | Per-switch wake enables |
| wake_n | input | 1 | Asynchronous active-low wake pin |
| int_n | input | 1 | Asynchronous active-low interrupt pin |
| cs_n | input | 1 | Asynchronous active-low chip-select pin |
| timer_expire | input | 1 | Interrupt timer expiry pulse |
| mode_sleep | output | 1 | Current mode, 1 = sleep, 0 = normal |
| spi_en | output | 1 | Serial register programming allowed |

## Verification
The bench builds the block with NUM_SW = 4 and SYNC_STAGES = 2. With four switches, all 256 combinations of enable mask and change pattern can each be applied from sleep mode. With two stages, the pin latency is a fixed three edges, so the bench can check that a wake arrives neither one cycle early nor late. The bench also sweeps every combination of logic supply and wake-pin level against the interrupt-pin and chip-select wake sources.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic {
    PM_NORMAL = 1'b0,
    PM_SLEEP  = 1'b1
  } pm_mode_e;

  // bit positions of the asynchronous pins inside the synchronizer vector
  localparam int PIN_WAKE  = 0;
  localparam int PIN_INT   = 1;
  localparam int PIN_CS    = 2;
  localparam int NUM_PINS  = 3;

endpackage

// File: rtl/pmc_edge_sync.sv
module pmc_edge_sync #(
  parameter int WIDTH     = 3,
  parameter int STAGES    = 2,
  parameter int LEVEL_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] fall_o,
  output logic             level_o
);

  localparam int TOP = STAGES - 1;

  // edges are suppressed on the first cycle after reset
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_pin
      logic [STAGES-1:0] chain;
      logic              prev;

      // the chain keeps shifting during reset so that it holds the real
      // pin level when reset is released; no false edge is produced
      always_ff @(posedge clk) begin
        chain <= {chain[TOP-1:0], pin_i[g]};
        prev  <= chain[TOP];
      end

      assign fall_o[g] = armed & prev & ~chain[TOP];

      if (g == LEVEL_IDX) begin : g_level
        assign level_o = chain[TOP];
      end
    end
  endgenerate

endmodule

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
  parameter int NUM_SW   = 8,
  parameter int NUM_PINS = 3
) (
  input  logic [NUM_SW-1:0]   sw_change,
  input  logic [NUM_SW-1:0]   sw_wake_en,
  input  logic [NUM_PINS-1:0] pin_fall,
  input  logic                wake_level,
  input  logic                supply_ok,
  input  logic                timer_expire,
  output logic                wake_any
);
  import pmc_pkg::*;

  logic sw_hit;
  logic wake_hit;
  logic int_hit;
  logic cs_hit;

  always_comb begin
    sw_hit   = |(sw_change & sw_wake_en);
    wake_hit = pin_fall[PIN_WAKE];
    int_hit  = pin_fall[PIN_INT] & supply_ok & wake_level;
    cs_hit   = pin_fall[PIN_CS] & supply_ok;
    wake_any = sw_hit | wake_hit | int_hit | cs_hit | timer_expire;
  end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm (
  input  logic clk,
  input  logic rst,
  input  logic sleep_cmd,
  input  logic wake_any,
  input  logic supply_ok,
  output logic mode_sleep,
  output logic spi_en
);
  import pmc_pkg::*;

  pm_mode_e mode_q, mode_d;
  logic     spi_en_q;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_NORMAL: if (sleep_cmd && spi_en_q) mode_d = PM_SLEEP;
      PM_SLEEP:  if (wake_any)              mode_d = PM_NORMAL;
      default:                              mode_d = PM_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= PM_NORMAL;
      spi_en_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      spi_en_q <= (mode_d == PM_NORMAL) && supply_ok;
    end
  end

  assign mode_sleep = (mode_q == PM_SLEEP);
  assign spi_en     = spi_en_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int NUM_SW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_cmd,
  input  logic              supply_ok,
  input  logic [NUM_SW-1:0] sw_change,
  input  logic [NUM_SW-1:0] sw_wake_en,
  input  logic              wake_n,
  input  logic              int_n,
  input  logic              cs_n,
  input  logic              timer_expire,
  output logic              mode_sleep,
  output logic              spi_en
);
  import pmc_pkg::*;

  logic [NUM_PINS-1:0] pins;
  logic [NUM_PINS-1:0] pin_fall;
  logic                wake_level;
  logic                wake_any;

  always_comb begin
    pins           = '1;
    pins[PIN_WAKE] = wake_n;
    pins[PIN_INT]  = int_n;
    pins[PIN_CS]   = cs_n;
  end

  pmc_edge_sync #(
    .WIDTH     (NUM_PINS),
    .STAGES    (SYNC_STAGES),
    .LEVEL_IDX (PIN_WAKE)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (pins),
    .fall_o  (pin_fall),
    .level_o (wake_level)
  );

  pmc_wake_qual #(
    .NUM_SW   (NUM_SW),
    .NUM_PINS (NUM_PINS)
  ) u_qual (
    .sw_change    (sw_change),
    .sw_wake_en   (sw_wake_en),
    .pin_fall     (pin_fall),
    .wake_level   (wake_level),
    .supply_ok    (supply_ok),
    .timer_expire (timer_expire),
    .wake_any     (wake_any)
  );

  pmc_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sleep_cmd  (sleep_cmd),
    .wake_any   (wake_any),
    .supply_ok  (supply_ok),
    .mode_sleep (mode_sleep),
    .spi_en     (spi_en)
  );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int NUM_SW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep_cmd,
  input logic              supply_ok,
  input logic [NUM_SW-1:0] sw_change,
  input logic [NUM_SW-1:0] sw_wake_en,
  input logic              timer_expire,
  input logic              wake_any,
  input logic              mode_sleep,
  input logic              spi_en
);

  assert_reset_normal_R1: assert property (@(posedge clk)
    rst |=> (!mode_sleep && !spi_en));

  assert_enter_sleep_R2: assert property (@(posedge clk) disable iff (rst)
    (spi_en && sleep_cmd) |=> mode_sleep);

  assert_no_sleep_without_en_R2: assert property (@(posedge clk) disable iff (rst)
    (!mode_sleep && !spi_en) |=> !mode_sleep);

  assert_switch_wake_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_sleep && |(sw_change & sw_wake_en)) |=> !mode_sleep);

  assert_timer_wake_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_sleep && timer_expire) |=> !mode_sleep);

  assert_sleep_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_sleep && !wake_any) |=> mode_sleep);

  assert_en_only_normal_R9: assert property (@(posedge clk) disable iff (rst)
    spi_en |-> !mode_sleep);

  assert_en_needs_supply_R9: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !spi_en);

endmodule

bind pwr_mode_ctrl pmc_checker #(.NUM_SW(NUM_SW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_cmd    (sleep_cmd),
  .supply_ok    (supply_ok),
  .sw_change    (sw_change),
  .sw_wake_en   (sw_wake_en),
  .timer_expire (timer_expire),
  .wake_any     (wake_any),
  .mode_sleep   (mode_sleep),
  .spi_en       (spi_en)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int NSW = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           sleep_cmd = 1'b0;
  logic           supply_ok = 1'b1;
  logic [NSW-1:0] sw_change = '0;
  logic [NSW-1:0] sw_wake_en = '0;
  logic           wake_n = 1'b1;
  logic           int_n = 1'b1;
  logic           cs_n = 1'b1;
  logic           timer_expire = 1'b0;
  logic           mode_sleep;
  logic           spi_en;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_SW(NSW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .sleep_cmd(sleep_cmd), .supply_ok(supply_ok),
    .sw_change(sw_change), .sw_wake_en(sw_wake_en), .wake_n(wake_n),
    .int_n(int_n), .cs_n(cs_n), .timer_expire(timer_expire),
    .mode_sleep(mode_sleep), .spi_en(spi_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // enter sleep through the command path (R2)
  task automatic go_sleep();
    @(negedge clk) supply_ok = 1'b1;
    @(negedge clk);
    chk("R9 en before sleep", spi_en, 1);
    sleep_cmd = 1'b1;
    @(negedge clk) sleep_cmd = 1'b0;
    chk("R2 enter sleep", mode_sleep, 1);
    chk("R9 en off in sleep", spi_en, 0);
  endtask

  task automatic timer_wake();
    timer_expire = 1'b1;
    @(negedge clk) timer_expire = 1'b0;
    chk("R7 timer wake", mode_sleep, 0);
  endtask

  initial begin
    cycles(2);
    chk("R1 mode in reset", mode_sleep, 0);
    chk("R1 en in reset", spi_en, 0);
    cycles(2);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mode after reset", mode_sleep, 0);
    chk("R9 en follows supply", spi_en, 1);

    // R8/R9: supply loss in normal mode; R2 command ignored without enable
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R8 normal kept", mode_sleep, 0);
    chk("R9 en drops", spi_en, 0);
    sleep_cmd = 1'b1;
    @(negedge clk) sleep_cmd = 1'b0;
    @(negedge clk);
    chk("R2 cmd ignored no en", mode_sleep, 0);

    // R10: wake sources in normal mode leave it normal, sleep still works
    supply_ok = 1'b1;
    sw_wake_en = '1; sw_change = '1; timer_expire = 1'b1; cs_n = 1'b0;
    @(negedge clk) sw_change = '0; timer_expire = 1'b0;
    cycles(4);
    chk("R10 normal ignores wakes", mode_sleep, 0);
    cs_n = 1'b1;
    cycles(4);
    go_sleep();
    timer_wake();

    // R3: every enable mask against every change pattern
    for (int en = 0; en < (1 << NSW); en++) begin
      for (int ch = 0; ch < (1 << NSW); ch++) begin
        go_sleep();
        sw_wake_en = NSW'(en);
        sw_change  = NSW'(ch);
        @(negedge clk) sw_change = '0;
        chk("R3 switch wake", mode_sleep, ((en & ch) == 0) ? 1 : 0);
        if (mode_sleep) timer_wake();
      end
    end
    sw_wake_en = '0;

    // R4/R8: wake pin with either supply level, latency of three edges
    for (int s = 0; s < 2; s++) begin
      go_sleep();
      supply_ok = s[0];
      cycles(3);
      chk("R8 sleep kept on supply change", mode_sleep, 1);
      wake_n = 1'b0;
      cycles(2);
      chk("R4 not yet awake", mode_sleep, 1);
      cycles(1);
      chk("R4 wake pin", mode_sleep, 0);
      wake_n = 1'b1;
      cycles(4);
    end

    // R5/R10: interrupt pin against supply and wake-pin level
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) begin
        wake_n = w[0];
        cycles(4);
        go_sleep();
        supply_ok = s[0];
        cycles(3);
        int_n = 1'b0;
        cycles(3);
        chk("R5 int wake", mode_sleep, (s == 1 && w == 1) ? 0 : 1);
        int_n = 1'b1;
        cycles(4);
        if (mode_sleep) begin
          wake_n = 1'b1;
          cycles(4);
          chk("R10 rising edges ignored", mode_sleep, 1);
          timer_wake();
        end
        wake_n = 1'b1;
        cycles(4);
      end
    end

    // R6: chip select against supply
    for (int s = 0; s < 2; s++) begin
      go_sleep();
      supply_ok = s[0];
      cycles(3);
      cs_n = 1'b0;
      cycles(3);
      chk("R6 cs wake", mode_sleep, (s == 1) ? 0 : 1);
      cs_n = 1'b1;
      cycles(4);
      if (mode_sleep) begin
        chk("R10 cs rise ignored", mode_sleep, 1);
        timer_wake();
      end
    end

    // R9: enable follows supply once back in normal mode
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R9 en low", spi_en, 0);
    supply_ok = 1'b1;
    @(negedge clk);
    chk("R9 en high", spi_en, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule